// File: doc/BRIEF.md
# Serial-Loaded Cartridge Bank Mapper

This block sits on the bus of an 8-bit CPU and translates the 32 KiB program window at 0x8000-0xFFFF into 16 KiB bank numbers of a ROM of up to 256 KiB. Software programs it through a narrow path: every write into the upper half of the address space carries one bit, data bit 0, into a 5-bit shift register. The fifth such write moves the gathered value into one of four registers. The address of that fifth write alone picks the target: the mode register, the lower graphics bank, the upper graphics bank or the program bank.

A write with data bit 7 set aborts a load in progress and returns the window to its power-on layout. In that layout the last ROM bank is pinned at 0xC000 and the switchable bank sits at 0x8000. A CPU read-modify-write instruction stores twice on adjacent cycles. To tolerate this, a write on the enabled cycle right after another upper-half write is dropped. The input `cyc_en` marks each CPU cycle. A ROM chip enable is raised for reads of the upper half. The two graphics bank registers are passed straight to outputs.

Top module: `serial_bank_mapper`

## Requirements
- R1: After reset the mode field (mode register bits 3:2) is 3, the shift register is empty, and the program, lower and upper graphics banks read 0.
- R2: An accepted upper-half write with data bit 7 set empties the shift register and sets the mode field to 3. Its other data bits, including bit 0, have no effect.
- R3: An accepted upper-half write with bit 7 clear shifts in data bit 0 only, first bit ending in bit 0 of the loaded value. Bits 6:1 are ignored.
- R4: The fifth accepted bit write loads the 5-bit value into the register chosen by address bits 14:13 of that write (0 mode, 1 lower graphics, 2 upper graphics, 3 program) and empties the shift register. The first four writes may use any upper-half address.
- R5: An upper-half write is ignored when the previous enabled cycle also carried an upper-half write, accepted or not. An enabled cycle without an upper-half write re-arms acceptance.
- R6: Reads, writes below 0x8000 and cycles with `cyc_en` low leave the shift register and all bank registers unchanged.
- R7: In mode 0 or 1 the window is one 32 KiB unit: `prg_bank` = {program bank bits 3:1, address bit 14}.
- R8: In mode 2 bank 0 appears at 0x8000-0xBFFF and the program bank at 0xC000-0xFFFF.
- R9: In mode 3 the program bank appears at 0x8000-0xBFFF and the last bank (all ones) at 0xC000-0xFFFF.
- R10: `rom_ce` is 1 exactly when `cpu_rd` is 1 and address bit 15 is 1.
- R11: `chr_lo_bank` and `chr_hi_bank` show the lower and upper graphics bank registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | One-clock strobe marking a CPU cycle |
| cpu_wr | input | 1 | CPU write in this cycle |
| cpu_rd | input | 1 | CPU read in this cycle |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| prg_bank | output | 4 | ROM address bits 17:14 for the current address |
| rom_ce | output | 1 | ROM chip enable for upper-half reads |
| chr_lo_bank | output | 5 | Lower graphics bank register |
| chr_hi_bank | output | 5 | Upper graphics bank register |

## Verification
`prg_bank` and `rom_ce` are combinational in the address, so they are due in the same cycle the address is driven. A register load appears from the first clock edge after the fifth accepted write. The bench drives inputs on the falling edge and compares all outputs 1 ns later against a behavioural model. That model is advanced only at the rising edge, so each comparison sees exactly the state the design has registered. Back-to-back and reset sequences are checked as they become visible through later loads and window reads.

// File: rtl/serial_bank_mapper.sv
module serial_bank_mapper #(
  parameter int SHIFT_W = 5,
  parameter int BANK_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_data,
  output logic [BANK_W-1:0] prg_bank,
  output logic              rom_ce,
  output logic [SHIFT_W-1:0] chr_lo_bank,
  output logic [SHIFT_W-1:0] chr_hi_bank
);
  localparam int CNT_W = $clog2(SHIFT_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SHIFT_W - 1);

  logic [SHIFT_W-1:0] shift_q, ctrl_q, chr_lo_q, chr_hi_q, prg_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               busy_q;

  wire map_wr = cyc_en & cpu_wr & cpu_addr[15];
  wire take   = map_wr & ~busy_q;
  wire full   = (cnt_q == LAST);
  wire [SHIFT_W-1:0] next_val = {cpu_data[0], shift_q[SHIFT_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q  <= '0;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      ctrl_q   <= SHIFT_W'(5'b01100);
      chr_lo_q <= '0;
      chr_hi_q <= '0;
      prg_q    <= '0;
    end else if (cyc_en) begin
      busy_q <= map_wr;
      if (take) begin
        if (cpu_data[7]) begin
          shift_q     <= '0;
          cnt_q       <= '0;
          ctrl_q[3:2] <= 2'b11;
        end else if (!full) begin
          shift_q <= next_val;
          cnt_q   <= cnt_q + 1'b1;
        end else begin
          shift_q <= '0;
          cnt_q   <= '0;
          case (cpu_addr[14:13])
            2'd0: ctrl_q   <= next_val;
            2'd1: chr_lo_q <= next_val;
            2'd2: chr_hi_q <= next_val;
            default: prg_q <= next_val;
          endcase
        end
      end
    end
  end

  wire [BANK_W-1:0] sel = prg_q[BANK_W-1:0];
  wire              hi  = cpu_addr[14];

  always_comb begin
    case (ctrl_q[3:2])
      2'b10:   prg_bank = hi ? sel : '0;
      2'b11:   prg_bank = hi ? '1 : sel;
      default: prg_bank = {sel[BANK_W-1:1], hi};
    endcase
  end

  assign rom_ce      = cpu_rd & cpu_addr[15];
  assign chr_lo_bank = chr_lo_q;
  assign chr_hi_bank = chr_hi_q;

  assert_reset_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cpu_data[7]) |=> (cnt_q == '0 && ctrl_q[3:2] == 2'b11));

  assert_back_to_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (map_wr && busy_q) |=> ($stable(shift_q) && $stable(cnt_q) && $stable(ctrl_q) && $stable(prg_q)));

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!map_wr) |=> ($stable(shift_q) && $stable(cnt_q) && $stable(ctrl_q) && $stable(prg_q)
                   && $stable(chr_lo_q) && $stable(chr_hi_q)));

  assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  assert_prg_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cpu_data[7] && full && cpu_addr[14:13] == 2'b11) |=> (prg_q == $past(next_val) && cnt_q == '0));
endmodule

// File: tb/tb_serial_bank_mapper.sv
`timescale 1ns/1ps
module tb_serial_bank_mapper;
  logic clk = 0, rst_n = 0, cyc_en = 0, cpu_wr = 0, cpu_rd = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_data = 0;
  logic [3:0]  prg_bank;
  logic        rom_ce;
  logic [4:0]  chr_lo_bank, chr_hi_bank;

  int checks = 0, errors = 0;
  int m_shift, m_cnt, m_busy, m_ctrl, m_chr0, m_chr1, m_prg;

  serial_bank_mapper dut (.clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .cpu_wr(cpu_wr),
    .cpu_rd(cpu_rd), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .prg_bank(prg_bank),
    .rom_ce(rom_ce), .chr_lo_bank(chr_lo_bank), .chr_hi_bank(chr_hi_bank));

  always #2 clk = ~clk;

  function automatic int exp_bank(int a);
    int mode = (m_ctrl >> 2) & 3;
    int h = (a >> 14) & 1;
    int p = m_prg & 15;
    if (mode == 2) return h ? p : 0;        // R8
    if (mode == 3) return h ? 15 : p;       // R9
    return (p & 14) | h;                    // R7
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_shift = 0; m_cnt = 0; m_busy = 0; m_ctrl = 12; m_chr0 = 0; m_chr1 = 0; m_prg = 0;
  endtask

  task automatic model_edge();
    int mw = cyc_en && cpu_wr && cpu_addr[15];
    if (!cyc_en) return;
    if (mw && !m_busy) begin
      if (cpu_data[7]) begin
        m_shift = 0; m_cnt = 0; m_ctrl = m_ctrl | 12;
      end else begin
        m_shift = m_shift | (int'(cpu_data[0]) << m_cnt);
        m_cnt++;
        if (m_cnt == 5) begin
          case (cpu_addr[14:13])
            0: m_ctrl = m_shift;
            1: m_chr0 = m_shift;
            2: m_chr1 = m_shift;
            default: m_prg = m_shift;
          endcase
          m_shift = 0; m_cnt = 0;
        end
      end
    end
    m_busy = mw;
  endtask

  task automatic step(string tag, bit en, bit wr, bit rd, logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cyc_en = en; cpu_wr = wr; cpu_rd = rd; cpu_addr = a; cpu_data = d;
    #1;
    chk({tag, " prg_bank"}, prg_bank, exp_bank(a));
    chk({tag, " rom_ce R10"}, rom_ce, int'(rd && a[15]));
    chk({tag, " chr_lo R11"}, chr_lo_bank, m_chr0);
    chk({tag, " chr_hi R11"}, chr_hi_bank, m_chr1);
    @(posedge clk);
    model_edge();
  endtask

  task automatic wr1(string tag, logic [15:0] a, logic [7:0] d);
    step(tag, 1, 1, 0, a, d);
    step(tag, 1, 0, 1, 16'h8000, 0);
  endtask

  task automatic load(string tag, logic [15:0] first, logic [15:0] last, int v);
    for (int i = 0; i < 5; i++)
      wr1(tag, (i == 4) ? last : first, 8'(((v >> i) & 1) | 8'h7E & 8'(i * 18)));
  endtask

  task automatic probe(string tag);
    step(tag, 1, 0, 1, 16'h8123, 0);
    step(tag, 1, 0, 1, 16'hA456, 0);
    step(tag, 1, 0, 1, 16'hC789, 0);
    step(tag, 1, 0, 1, 16'hFFFC, 0);
    step(tag, 1, 0, 1, 16'h4000, 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    probe("R1 reset state R9");
    load("R4 prg via E000", 16'h8000, 16'hE000, 5'd5);
    probe("R9 mode3 bank5");
    load("R4 chr lo via A000", 16'hF000, 16'hA000, 5'd19);
    load("R4 chr hi via C000", 16'h9000, 16'hC000, 5'd10);
    probe("R11 chr outputs");
    load("R4 mode2", 16'hE000, 16'h8000, 5'h08);
    load("R3 prg 9", 16'hA000, 16'hE000, 5'd9);
    probe("R8 mode2");
    load("R7 mode0", 16'hC000, 16'h8000, 5'h00);
    probe("R7 mode0");
    load("R7 mode1", 16'hC000, 16'h9FFF, 5'h04);
    probe("R7 mode1");
    wr1("R2 partial a", 16'hE000, 1);
    wr1("R2 partial b", 16'hE000, 1);
    wr1("R2 reset write", 16'hB000, 8'hFF);
    probe("R2 mode forced 3");
    load("R2 clean load after reset", 16'h8000, 16'hE000, 5'd3);
    probe("R2 prg 3");
    for (int i = 0; i < 5; i++) begin
      step("R5 rmw first", 1, 1, 0, 16'hE000, 8'((12 >> i) & 1));
      step("R5 rmw second", 1, 1, 0, 16'hE000, 8'(~(12 >> i) & 1));
      step("R5 rmw third", 1, 1, 0, 16'hC000, 8'h80);
      step("R5 idle", 1, 0, 0, 16'h0000, 0);
    end
    probe("R5 prg 12");
    step("R5 reset then write", 1, 1, 0, 16'h8000, 8'h80);
    step("R5 reset then write", 1, 1, 0, 16'h8000, 8'h01);
    step("R5 idle", 1, 0, 1, 16'h8000, 0);
    load("R5 register empty", 16'h8000, 16'hE000, 5'd6);
    probe("R5 prg 6");
    for (int i = 0; i < 5; i++) begin
      step("R6 no strobe", 0, 1, 0, 16'hE000, 8'h01);
      step("R6 low write", 1, 1, 0, 16'h6000, 8'h01);
      step("R6 read", 1, 0, 1, 16'hE000, 8'h01);
    end
    probe("R6 unchanged");
    for (int i = 0; i < 5; i++) begin
      step("R6 gap low strobe", 1, 1, 0, 16'hE000, 8'(i == 1 ? 1 : 0));
      step("R6 gap", 0, 0, 0, 16'h0000, 0);
      step("R6 gap idle", 1, 0, 0, 16'h0000, 0);
    end
    probe("R6 prg 2");
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule